// File: doc/BRIEF.md
# IR Pulse-Distance Frame Decoder

This block turns the demodulated, already synchronized output of an infrared remote receiver into decoded key codes. The receiver line idles high. A transmitted light burst (a mark) pulls it low, and a gap (a space) leaves it high. A frame opens with a long mark and a long space. Twenty-four data bits follow. Each bit is a short mark, then a short space for a zero or a space about twice as long for a one. One more short mark closes the frame.

The decoder times every run of constant level in clock cycles and sorts it into one of five duration classes: header mark, header space, bit mark, zero space and one space. Each class has its own window, and both bounds of every window are exclusive. The first twelve bits carry an address nibble and a command byte. The last twelve bits carry their bitwise complements. The decoder checks those complements before it reports anything.

A good frame yields a one-cycle strobe, and the address and command outputs are updated at the same time. A run that fits no window at its position, or a failed complement check, yields a one-cycle error strobe and sends the decoder back to idle. All window bounds are parameters in clock cycles. The defaults assume a 50 MHz clock.

Top module: `irpd_frame_decoder`

## Requirements
- R1: While reset is asserted and on the first clock after its release, frame_vld, frame_err, addr and cmd are all zero.
- R2: A low level on rx_n is a mark and a high level is a space. A run of N consecutive sampled clocks at one level is classified with exclusive bounds. Header mark needs HM_LO < N < HM_HI. Header space needs HS_LO < N < HS_HI. Bit mark needs BM_LO < N < BM_HI. Zero space needs ZS_LO < N < ZS_HI. One space needs OS_LO < N < OS_HI. A run exactly on a bound is outside the window.
- R3: The 24 data bits are taken most significant bit first, with a zero space meaning 0 and a one space meaning 1. Bits 23..20 are the address, bits 19..12 are the command, bits 11..8 are the inverted address and bits 7..0 are the inverted command. For example, address 0x5 with command 0x2A is the bit string 0101 00101010 1010 11010101.
- R4: frame_vld is high for exactly one clock. That clock is the one after the clock edge that first samples rx_n high at the end of the trailing bit mark. frame_vld is never raised earlier.
- R5: If the inverted fields do not match the inverses of the address and command, the end of the trailing mark raises frame_err for one clock instead of frame_vld.
- R6: Inside a frame, a run that misses the window expected at its position raises frame_err for one clock. This covers a wrong class, a length between windows, a length on a bound and a bad trailing mark. The error appears on the clock after the edge that samples the level change. The decoder then waits for a new header.
- R7: Inside a frame, a level held for RUN_MAX sampled clocks without a change raises frame_err on the clock after the RUN_MAX-th sample. RUN_MAX is the largest upper bound among the windows.
- R8: While idle, the decoder ignores every run except a valid header mark. It raises no error and updates no output.
- R9: addr and cmd change only together with frame_vld. Errors leave them at the last decoded values.
- R10: frame_vld and frame_err are never high in the same clock. Each strobe is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_n | input | 1 | Synchronized receiver output, low during a mark |
| frame_vld | output | 1 | One-clock strobe for a decoded frame |
| frame_err | output | 1 | One-clock strobe for a rejected frame |
| addr | output | ADDR_W | Address of the last good frame |
| cmd | output | CMD_W | Command of the last good frame |

## Verification
The bench builds the decoder with windows a few tens of cycles wide. The chosen bounds are header mark 40/48, header space 36/42, bit mark 5/9, zero space 10/14 and one space 20/26. With these values a whole frame takes well under a thousand clocks. Dozens of random frames fit in the run, and the bench can place a run exactly on each exclusive bound, one cycle inside it, or in the gap between two space windows. Because the header mark's upper bound of 48 is also the saturation limit, the stuck-level timeout can be reached and timed cycle by cycle.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

   // Duration classes produced by the classifier; NONE means no window matched.
   typedef enum logic [2:0] {
      BIN_NONE   = 3'd0,
      BIN_HMARK  = 3'd1,
      BIN_HSPACE = 3'd2,
      BIN_BMARK  = 3'd3,
      BIN_ZERO   = 3'd4,
      BIN_ONE    = 3'd5
   } irpd_bin_e;

   localparam int unsigned NUM_BINS = 5;

   // Frame sequencer states.
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_HSPACE = 2'd1,
      ST_BMARK  = 2'd2,
      ST_BSPACE = 2'd3
   } irpd_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/irpd_run_timer.sv
module irpd_run_timer #(
   parameter int unsigned RUN_MAX = 48,
   parameter int unsigned CNT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_n,
   output logic             edge_seen,
   output logic             run_was_mark,
   output logic [CNT_W-1:0] run_len,
   output logic             overrun
);

   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(RUN_MAX);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_MAX - 1);

   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;

   // A run ends in the cycle where the sampled level differs from the stored one.
   assign edge_seen    = (rx_n != lvl_q);
   assign run_was_mark = ~lvl_q;
   assign run_len      = cnt_q;
   assign overrun      = ~edge_seen && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b1;
         cnt_q <= CNT_SAT;
      end else begin
         lvl_q <= rx_n;
         if (edge_seen) begin
            cnt_q <= CNT_W'(1);
         end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/irpd_classifier.sv
module irpd_classifier
   import irpd_pkg::*;
#(
   parameter int unsigned HM_LO = 200500,
   parameter int unsigned HM_HI = 203500,
   parameter int unsigned HS_LO = 195000,
   parameter int unsigned HS_HI = 200000,
   parameter int unsigned BM_LO = 25000,
   parameter int unsigned BM_HI = 28000,
   parameter int unsigned ZS_LO = 45000,
   parameter int unsigned ZS_HI = 50000,
   parameter int unsigned OS_LO = 97000,
   parameter int unsigned OS_HI = 100000,
   parameter int unsigned CNT_W = 18
) (
   input  logic [CNT_W-1:0] run_len,
   input  logic             run_was_mark,
   output irpd_bin_e        bin_o
);

   localparam int unsigned LO_T [NUM_BINS] = '{HM_LO, HS_LO, BM_LO, ZS_LO, OS_LO};
   localparam int unsigned HI_T [NUM_BINS] = '{HM_HI, HS_HI, BM_HI, ZS_HI, OS_HI};
   // Bit k set: window k applies to marks (low level), else to spaces.
   localparam logic [NUM_BINS-1:0] MARK_SEL = 5'b00101;

   logic [NUM_BINS-1:0] hit;

   for (genvar k = 0; k < NUM_BINS; k++) begin : g_win
      if (LO_T[k] + 1 >= HI_T[k]) begin : g_empty
         $error("irpd_classifier: window %0d has no cycle strictly inside it", k);
      end
      if (HI_T[k] >= (1 << CNT_W)) begin : g_wide
         $error("irpd_classifier: window %0d exceeds the counter range", k);
      end
      assign hit[k] = (run_was_mark == MARK_SEL[k]) &&
                      (run_len > CNT_W'(LO_T[k])) &&
                      (run_len < CNT_W'(HI_T[k]));
   end

   always_comb begin
      bin_o = BIN_NONE;
      for (int k = NUM_BINS - 1; k >= 0; k--) begin
         if (hit[k]) begin
            bin_o = irpd_bin_e'(3'(k + 1));
         end
      end
   end

endmodule

// File: rtl/irpd_frame_fsm.sv
module irpd_frame_fsm
   import irpd_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_seen,
   input  logic              overrun,
   input  irpd_bin_e         bin_i,
   output logic              frame_vld,
   output logic              frame_err,
   output logic [ADDR_W-1:0] addr,
   output logic [CMD_W-1:0]  cmd
);

   localparam int unsigned FRAME_BITS = 2 * (ADDR_W + CMD_W);
   localparam int unsigned BITCNT_W   = $clog2(FRAME_BITS + 1);
   localparam logic [BITCNT_W-1:0] NB_FULL = BITCNT_W'(FRAME_BITS);

   irpd_state_e           st_q, st_d;
   logic [FRAME_BITS-1:0] sr_q, sr_d;
   logic [BITCNT_W-1:0]   nb_q, nb_d;
   logic                  vld_q, vld_d, err_q, err_d;
   logic [ADDR_W-1:0]     addr_q, addr_d;
   logic [CMD_W-1:0]      cmd_q, cmd_d;

   // Field slices of the completed shift register, first-received bit on top.
   logic [ADDR_W-1:0] f_addr, f_addr_inv;
   logic [CMD_W-1:0]  f_cmd, f_cmd_inv;
   logic              inv_ok;

   assign f_addr     = sr_q[FRAME_BITS-1 -: ADDR_W];
   assign f_cmd      = sr_q[FRAME_BITS-ADDR_W-1 -: CMD_W];
   assign f_addr_inv = sr_q[CMD_W +: ADDR_W];
   assign f_cmd_inv  = sr_q[0 +: CMD_W];
   assign inv_ok     = (f_addr_inv == ~f_addr) && (f_cmd_inv == ~f_cmd);

   always_comb begin
      st_d   = st_q;
      sr_d   = sr_q;
      nb_d   = nb_q;
      vld_d  = 1'b0;
      err_d  = 1'b0;
      addr_d = addr_q;
      cmd_d  = cmd_q;
      if (edge_seen) begin
         unique case (st_q)
            ST_IDLE: begin
               if (bin_i == BIN_HMARK) begin
                  st_d = ST_HSPACE;
               end
            end
            ST_HSPACE: begin
               if (bin_i == BIN_HSPACE) begin
                  st_d = ST_BMARK;
                  nb_d = '0;
               end else begin
                  st_d  = ST_IDLE;
                  err_d = 1'b1;
               end
            end
            ST_BMARK: begin
               if (bin_i != BIN_BMARK) begin
                  st_d  = ST_IDLE;
                  err_d = 1'b1;
               end else if (nb_q == NB_FULL) begin
                  st_d = ST_IDLE;
                  if (inv_ok) begin
                     vld_d  = 1'b1;
                     addr_d = f_addr;
                     cmd_d  = f_cmd;
                  end else begin
                     err_d = 1'b1;
                  end
               end else begin
                  st_d = ST_BSPACE;
               end
            end
            ST_BSPACE: begin
               if (bin_i == BIN_ZERO || bin_i == BIN_ONE) begin
                  sr_d = {sr_q[FRAME_BITS-2:0], (bin_i == BIN_ONE)};
                  nb_d = nb_q + BITCNT_W'(1);
                  st_d = ST_BMARK;
               end else begin
                  st_d  = ST_IDLE;
                  err_d = 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end else if (overrun && st_q != ST_IDLE) begin
         st_d  = ST_IDLE;
         err_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sr_q   <= '0;
         nb_q   <= '0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
         addr_q <= '0;
         cmd_q  <= '0;
      end else begin
         st_q   <= st_d;
         sr_q   <= sr_d;
         nb_q   <= nb_d;
         vld_q  <= vld_d;
         err_q  <= err_d;
         addr_q <= addr_d;
         cmd_q  <= cmd_d;
      end
   end

   assign frame_vld = vld_q;
   assign frame_err = err_q;
   assign addr      = addr_q;
   assign cmd       = cmd_q;

endmodule

// File: rtl/irpd_frame_decoder.sv
module irpd_frame_decoder
   import irpd_pkg::*;
#(
   parameter int unsigned HM_LO  = 200500,
   parameter int unsigned HM_HI  = 203500,
   parameter int unsigned HS_LO  = 195000,
   parameter int unsigned HS_HI  = 200000,
   parameter int unsigned BM_LO  = 25000,
   parameter int unsigned BM_HI  = 28000,
   parameter int unsigned ZS_LO  = 45000,
   parameter int unsigned ZS_HI  = 50000,
   parameter int unsigned OS_LO  = 97000,
   parameter int unsigned OS_HI  = 100000,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_n,
   output logic              frame_vld,
   output logic              frame_err,
   output logic [ADDR_W-1:0] addr,
   output logic [CMD_W-1:0]  cmd
);

   localparam int unsigned RUN_MAX = umax(umax(umax(HM_HI, HS_HI), umax(BM_HI, ZS_HI)), OS_HI);
   localparam int unsigned CNT_W   = $clog2(RUN_MAX + 1);

   if (ADDR_W < 1 || CMD_W < 1) begin : g_bad_fields
      $error("irpd_frame_decoder: field widths must be at least one bit");
   end
   if (ZS_HI > OS_LO || OS_HI > HS_LO || BM_HI > HM_LO) begin : g_bad_order
      $error("irpd_frame_decoder: duration windows overlap or are out of order");
   end

   logic             edge_seen, run_was_mark, overrun;
   logic [CNT_W-1:0] run_len;
   irpd_bin_e        bin;

   irpd_run_timer #(
      .RUN_MAX (RUN_MAX),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_n         (rx_n),
      .edge_seen    (edge_seen),
      .run_was_mark (run_was_mark),
      .run_len      (run_len),
      .overrun      (overrun)
   );

   irpd_classifier #(
      .HM_LO (HM_LO), .HM_HI (HM_HI),
      .HS_LO (HS_LO), .HS_HI (HS_HI),
      .BM_LO (BM_LO), .BM_HI (BM_HI),
      .ZS_LO (ZS_LO), .ZS_HI (ZS_HI),
      .OS_LO (OS_LO), .OS_HI (OS_HI),
      .CNT_W (CNT_W)
   ) u_class (
      .run_len      (run_len),
      .run_was_mark (run_was_mark),
      .bin_o        (bin)
   );

   irpd_frame_fsm #(
      .ADDR_W (ADDR_W),
      .CMD_W  (CMD_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_seen (edge_seen),
      .overrun   (overrun),
      .bin_i     (bin),
      .frame_vld (frame_vld),
      .frame_err (frame_err),
      .addr      (addr),
      .cmd       (cmd)
   );

endmodule

// File: rtl/irpd_decoder_chk.sv
module irpd_decoder_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CMD_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_n,
   input logic              frame_vld,
   input logic              frame_err,
   input logic [ADDR_W-1:0] addr,
   input logic [CMD_W-1:0]  cmd
);

   // R10
   vld_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_vld && frame_err));

   // R10
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |=> !frame_vld);

   // R10
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R4
   vld_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |-> ($past(rx_n) && !$past(rx_n, 2)));

   // R9
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |-> ($stable(addr) && $stable(cmd)));

endmodule

bind irpd_frame_decoder irpd_decoder_chk #(
   .ADDR_W (ADDR_W),
   .CMD_W  (CMD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_n      (rx_n),
   .frame_vld (frame_vld),
   .frame_err (frame_err),
   .addr      (addr),
   .cmd       (cmd)
);

// File: tb/tb_irpd_frame_decoder.sv
module tb_irpd_frame_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int HM_LO = 40, HM_HI = 48, HS_LO = 36, HS_HI = 42;
   localparam int BM_LO = 5,  BM_HI = 9,  ZS_LO = 10, ZS_HI = 14;
   localparam int OS_LO = 20, OS_HI = 26;
   localparam int RUN_MAX = 48;
   localparam int GAP = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_n = 1'b1;
   logic       frame_vld, frame_err;
   logic [3:0] addr;
   logic [7:0] cmd;

   int checks = 0, errors = 0;
   int vld_seen = 0, err_seen = 0, exp_vld = 0, exp_err = 0;
   logic [3:0] last_a = '0;
   logic [7:0] last_c = '0;
   bit done = 1'b0;

   irpd_frame_decoder #(
      .HM_LO(HM_LO), .HM_HI(HM_HI), .HS_LO(HS_LO), .HS_HI(HS_HI),
      .BM_LO(BM_LO), .BM_HI(BM_HI), .ZS_LO(ZS_LO), .ZS_HI(ZS_HI),
      .OS_LO(OS_LO), .OS_HI(OS_HI), .ADDR_W(4), .CMD_W(8)
   ) dut (
      .clk(clk), .rst_n(rst_n), .rx_n(rx_n),
      .frame_vld(frame_vld), .frame_err(frame_err), .addr(addr), .cmd(cmd)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Strobe monitor, sampled shortly after each rising edge.
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (frame_vld) vld_seen++;
         if (frame_err) err_seen++;
         if (frame_vld && frame_err) begin
            errors++;
            $display("FAIL R10 both strobes high actual=11 expected=not both");
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] mk_word(input logic [3:0] a, input logic [7:0] c);
      return {a, c, ~a, ~c};
   endfunction

   // mode 0: random inside window, 1: lo+1, 2: hi-1
   function automatic int pick(input int lo, input int hi, input int mode);
      if (mode == 1) return lo + 1;
      if (mode == 2) return hi - 1;
      return lo + 1 + int'($urandom % 32'(hi - lo - 1));
   endfunction

   task automatic hold(input logic lvl, input int n);
      rx_n = lvl;
      repeat (n) @(negedge clk);
   endtask

   // kind 0: good, 1: error at end of pulse bad_idx, 2: error at trailing end, 3: silently ignored
   task automatic run_frame(input logic [23:0] w, input int mode, input int bad_idx,
                            input int bad_len, input int kind, input string tag);
      int e0;
      e0 = err_seen;
      for (int p = 0; p < 51; p++) begin
         logic lvl;
         int   len;
         lvl = (p % 2 == 0) ? 1'b0 : 1'b1;
         if (p == 0)           len = pick(HM_LO, HM_HI, mode);
         else if (p == 1)      len = pick(HS_LO, HS_HI, mode);
         else if (p % 2 == 0)  len = pick(BM_LO, BM_HI, mode);
         else if (w[23 - (p - 3) / 2]) len = pick(OS_LO, OS_HI, mode);
         else                  len = pick(ZS_LO, ZS_HI, mode);
         if (p == bad_idx) len = bad_len;
         hold(lvl, len);
         if (p == bad_idx && kind == 1) begin
            rx_n = ~lvl;
            @(negedge clk);
            check({"R6 error strobe ", tag}, 32'(frame_err), 32'd1);
            check({"R6 no valid ", tag}, 32'(frame_vld), 32'd0);
            exp_err++;
            @(negedge clk);
            check({"R10 error one cycle ", tag}, 32'(frame_err), 32'd0);
            check({"R9 addr kept ", tag}, 32'(addr), 32'(last_a));
            hold(1'b1, GAP);
            return;
         end
      end
      check({"R4 no early valid ", tag}, 32'(frame_vld), 32'd0);
      rx_n = 1'b1;
      @(negedge clk);
      if (kind == 0) begin
         check({"R4 valid strobe ", tag}, 32'(frame_vld), 32'd1);
         check({"R3 addr ", tag}, 32'(addr), 32'(w[23:20]));
         check({"R3 cmd ", tag}, 32'(cmd), 32'(w[19:12]));
         last_a = w[23:20];
         last_c = w[19:12];
         exp_vld++;
      end else if (kind == 2) begin
         check({"R5 error strobe ", tag}, 32'(frame_err), 32'd1);
         check({"R5 no valid ", tag}, 32'(frame_vld), 32'd0);
         check({"R9 addr kept ", tag}, 32'(addr), 32'(last_a));
         check({"R9 cmd kept ", tag}, 32'(cmd), 32'(last_c));
         exp_err++;
      end else begin
         check({"R8 no valid ", tag}, 32'(frame_vld), 32'd0);
         check({"R8 no error ", tag}, 32'(err_seen - e0), 32'd0);
         check({"R8 cmd kept ", tag}, 32'(cmd), 32'(last_c));
      end
      @(negedge clk);
      check({"R10 strobes one cycle ", tag}, 32'({frame_vld, frame_err}), 32'd0);
      hold(1'b1, GAP);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset vld", 32'(frame_vld), 32'd0);
      check("R1 reset err", 32'(frame_err), 32'd0);
      check("R1 reset addr", 32'(addr), 32'd0);
      check("R1 reset cmd", 32'(cmd), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'({frame_vld, frame_err, addr, cmd}), 32'd0);
      hold(1'b1, 5);

      check("R3 reference word", 32'(mk_word(4'h5, 8'h2A)), 32'b0101_00101010_1010_11010101);
      run_frame(mk_word(4'h5, 8'h2A), 0, -1, 0, 0, "reference");
      run_frame(mk_word(4'hA, 8'hC3), 1, -1, 0, 0, "R2 inner low bounds");
      run_frame(mk_word(4'h3, 8'h5E), 2, -1, 0, 0, "R2 inner high bounds");

      // R2 / R8: header mark exactly on a bound is not a header
      run_frame(mk_word(4'h1, 8'h11), 0, 0, HM_LO, 3, "R2 hdr mark at low bound");
      run_frame(mk_word(4'h2, 8'h22), 0, 0, HM_HI, 3, "R2 hdr mark at high bound");

      // R6: runs that miss their window
      run_frame(mk_word(4'h6, 8'h66), 0, 1, HS_HI, 1, "R6 hdr space at high bound");
      run_frame(mk_word(4'h6, 8'h66), 0, 1, HS_LO, 1, "R6 hdr space at low bound");
      run_frame(mk_word(4'h7, 8'h77), 0, 2, BM_LO, 1, "R6 bit mark at low bound");
      run_frame(mk_word(4'h7, 8'h77), 0, 10, BM_HI, 1, "R6 bit mark at high bound");
      run_frame(mk_word(4'h8, 8'h88), 0, 3, ZS_LO, 1, "R6 space at zero low bound");
      run_frame(mk_word(4'h8, 8'h88), 0, 5, 17, 1, "R6 space between windows");
      run_frame(mk_word(4'h9, 8'h99), 0, 7, OS_HI, 1, "R6 space at one high bound");
      run_frame(mk_word(4'h9, 8'h99), 0, 9, 39, 1, "R6 header-length space in data");
      run_frame(mk_word(4'hB, 8'hBB), 0, 50, 3, 1, "R6 short trailing mark");

      // R5: complement failures
      run_frame(mk_word(4'hC, 8'hCC) ^ 24'h000100, 0, -1, 0, 2, "R5 inverted addr bit");
      run_frame(mk_word(4'hD, 8'hDD) ^ 24'h000001, 0, -1, 0, 2, "R5 inverted cmd bit");

      // R7: level stuck high after a good header
      hold(1'b0, 44);
      hold(1'b1, RUN_MAX - 1);
      check("R7 no error before limit", 32'(frame_err), 32'd0);
      @(negedge clk);
      check("R7 error at limit", 32'(frame_err), 32'd1);
      exp_err++;
      @(negedge clk);
      check("R7 error one cycle", 32'(frame_err), 32'd0);
      hold(1'b1, GAP);

      // R8: noise in idle, then a good frame
      begin
         int e0;
         e0 = err_seen;
         hold(1'b0, 7);  hold(1'b1, 10);
         hold(1'b0, 3);  hold(1'b1, 23);
         hold(1'b0, 1);  hold(1'b1, 20);
         check("R8 idle noise no error", 32'(err_seen - e0), 32'd0);
         check("R8 idle noise addr kept", 32'(addr), 32'(last_a));
      end
      run_frame(mk_word(4'hE, 8'h0F), 0, -1, 0, 0, "R8 frame after noise");

      // R3: random frames
      for (int i = 0; i < 30; i++) begin
         logic [3:0] ra;
         logic [7:0] rc;
         ra = 4'($urandom);
         rc = 8'($urandom);
         run_frame(mk_word(ra, rc), 0, -1, 0, 0, "R3 random");
      end

      check("R10 valid strobe count", 32'(vld_seen), 32'(exp_vld));
      check("R10 error strobe count", 32'(err_seen), 32'(exp_err));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule